// File: doc/BRIEF.md
# Armed-Trigger Event Sampling Counter

This block counts qualifying event pulses in a wide up-counter and turns counter wraps into sample requests for a downstream record-capture engine. A wrap from all ones to zero does two things. It can raise a one-cycle overflow interrupt, and it arms the sampler. It does not request a sample by itself. The next counted event steps the counter from zero to one, and that event issues the sample request. The request is then held until the capture engine acknowledges it.

On the acknowledge, the live counter is loaded from a separately programmed reload register. Software normally writes a negative value there. A reload of minus N gives one sample for every N+1 counted events, because N events bring the counter back to zero and one more event fires the sampler. A reload of zero means the counter must run through its whole range before it wraps again.

Software reaches the block through a small write port. The port selects the live counter, the reload register or a control word that holds an enable bit and an interrupt-enable bit. The live count is visible on an output. An elaboration option can place one register stage on the event input.

Top module: `evsamp_unit`

## Requirements
- R1: When the enable bit (control bit 0) is set, each cycle with `evt_i` high adds one to `count_o`, wrapping modulo 2^CNT_W. When the enable bit is clear, events leave `count_o` unchanged.
- R2: When a counted event takes `count_o` from all ones to zero and the interrupt-enable bit (control bit 1) is set, `irq_o` is high for exactly the following cycle. With the interrupt-enable bit clear, the wrap raises no interrupt.
- R3: A wrap arms the sampler but does not raise `samp_req_o` in the cycle it happens. The wrap arms the sampler whatever the interrupt-enable bit holds.
- R4: With the sampler armed, the next counted event raises `samp_req_o`. At that point `count_o` reads 1, and the armed state is cleared.
- R5: `samp_req_o` stays high until a cycle with `samp_ack_i` high. A `samp_ack_i` pulse while no request is pending has no effect on `count_o` or `samp_req_o`.
- R6: An accepted acknowledge drops `samp_req_o` and loads `count_o` from the reload register. If an event arrives in the same cycle, the reload wins and the event is not added.
- R7: While a request is pending, events still advance `count_o`. A wrap during that time neither arms nor fires the sampler, so after the acknowledge the next sample needs a fresh wrap.
- R8: A software write to the live counter clears the armed state. It also takes priority over a coincident event or reload.
- R9: With reload value 2^CNT_W - N and the counter started at that value, with prompt acknowledges, exactly one request is raised per N+1 events: on event number N+1 of each group, and never on the other events.
- R10: Write-port encoding: `wr_sel_i` = 0 writes the live counter, 1 writes the reload register, 2 writes the control word (bit 0 enable, bit 1 interrupt enable), and 3 is ignored.
- R11: After reset, `count_o`, the reload value and the control word are zero, and `irq_o` and `samp_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 1 | Qualifying event, one per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | CNT_W | Write data |
| count_o | output | CNT_W | Live counter value |
| irq_o | output | 1 | Overflow interrupt pulse |
| samp_req_o | output | 1 | Sample request, held until acknowledged |
| samp_ack_i | input | 1 | Sample acknowledge |

## Verification
The risky overlap is an acknowledge that lands in the same cycle as a counted event. Here the reload and the increment compete for the counter. The bench drives both inputs in one cycle and requires the count to equal the reload value exactly, with no extra one added. A second overlap is a wrap that occurs while a request is still pending. The bench holds off the acknowledge across a full counter lap, then checks that the first event after the reload does not fire. Firing there would show a stale arm left over from the pending period.

// File: rtl/evsamp_pkg.sv
package evsamp_pkg;

   typedef enum logic [1:0] {
      SEL_COUNT  = 2'd0,
      SEL_RELOAD = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_NONE   = 2'd3
   } wr_sel_e;

   typedef struct packed {
      logic irq_en;
      logic cnt_en;
   } ctrl_t;

   localparam int unsigned CTRL_BITS = $bits(ctrl_t);

endpackage

// File: rtl/evsamp_regs.sv
module evsamp_regs
   import evsamp_pkg::*;
#(
   parameter int unsigned CNT_W = 48
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic             cnt_load_o,
   output logic [CNT_W-1:0] cnt_val_o,
   output logic [CNT_W-1:0] reload_o,
   output ctrl_t            ctrl_o
);

   wr_sel_e             sel;
   logic [CNT_W-1:0]    reload_q;
   ctrl_t               ctrl_q;
   logic                reload_we;
   logic                ctrl_we;

   assign sel        = wr_sel_e'(wr_sel_i);
   assign cnt_load_o = wr_en_i && (sel == SEL_COUNT);
   assign reload_we  = wr_en_i && (sel == SEL_RELOAD);
   assign ctrl_we    = wr_en_i && (sel == SEL_CTRL);
   assign cnt_val_o  = wr_data_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         reload_q <= '0;
      end else if (reload_we) begin
         reload_q <= wr_data_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q <= ctrl_t'(wr_data_i[CTRL_BITS-1:0]);
      end
   end

   assign reload_o = reload_q;
   assign ctrl_o   = ctrl_q;

endmodule

// File: rtl/evsamp_evin.sv
module evsamp_evin #(
   parameter int unsigned EVT_STAGES = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic evt_i,
   input  logic en_i,
   output logic inc_o
);

   logic evt_s;

   generate
      if (EVT_STAGES == 0) begin : g_direct
         assign evt_s = evt_i;
      end else begin : g_staged
         logic evt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               evt_q <= 1'b0;
            end else begin
               evt_q <= evt_i;
            end
         end
         assign evt_s = evt_q;
      end
   endgenerate

   assign inc_o = evt_s && en_i;

endmodule

// File: rtl/evsamp_counter.sv
module evsamp_counter #(
   parameter int unsigned CNT_W = 48
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             inc_i,
   input  logic             sw_load_i,
   input  logic [CNT_W-1:0] sw_val_i,
   input  logic             rl_load_i,
   input  logic [CNT_W-1:0] rl_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step   = inc_i && !sw_load_i && !rl_load_i;
   assign wrap_o = step && (cnt_q == CNT_MAX);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (sw_load_i) begin
         cnt_q <= sw_val_i;
      end else if (rl_load_i) begin
         cnt_q <= rl_val_i;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/evsamp_sampler.sv
module evsamp_sampler (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic inc_i,
   input  logic wrap_i,
   input  logic sw_load_i,
   input  logic ack_i,
   input  logic irq_en_i,
   output logic armed_o,
   output logic req_o,
   output logic ack_take_o,
   output logic irq_o
);

   logic armed_q;
   logic req_q;
   logic irq_q;
   logic fire;

   assign fire       = inc_i && armed_q && !req_q && !sw_load_i;
   assign ack_take_o = ack_i && req_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
      end else if (sw_load_i || fire) begin
         armed_q <= 1'b0;
      end else if (wrap_i && !req_q) begin
         armed_q <= 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q <= 1'b0;
      end else if (fire) begin
         req_q <= 1'b1;
      end else if (ack_take_o) begin
         req_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= wrap_i && irq_en_i;
      end
   end

   assign armed_o = armed_q;
   assign req_o   = req_q;
   assign irq_o   = irq_q;

endmodule

// File: rtl/evsamp_unit.sv
module evsamp_unit
   import evsamp_pkg::*;
#(
   parameter int unsigned CNT_W      = 48,
   parameter int unsigned EVT_STAGES = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             evt_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o,
   output logic             samp_req_o,
   input  logic             samp_ack_i
);

   generate
      if (CNT_W < CTRL_BITS || CNT_W > 64) begin : g_bad_width
         $error("evsamp_unit: CNT_W out of range");
      end
      if (EVT_STAGES > 1) begin : g_bad_stages
         $error("evsamp_unit: EVT_STAGES must be 0 or 1");
      end
   endgenerate

   logic             cnt_load;
   logic [CNT_W-1:0] cnt_val;
   logic [CNT_W-1:0] reload_q;
   ctrl_t            ctrl_q;
   logic             inc;
   logic             wrap;
   logic             ack_take;
   logic             armed;

   evsamp_regs #(.CNT_W(CNT_W)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_sel_i   (wr_sel_i),
      .wr_data_i  (wr_data_i),
      .cnt_load_o (cnt_load),
      .cnt_val_o  (cnt_val),
      .reload_o   (reload_q),
      .ctrl_o     (ctrl_q)
   );

   evsamp_evin #(.EVT_STAGES(EVT_STAGES)) u_evin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i),
      .en_i   (ctrl_q.cnt_en),
      .inc_o  (inc)
   );

   evsamp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (inc),
      .sw_load_i (cnt_load),
      .sw_val_i  (cnt_val),
      .rl_load_i (ack_take),
      .rl_val_i  (reload_q),
      .cnt_o     (count_o),
      .wrap_o    (wrap)
   );

   evsamp_sampler u_smp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (inc),
      .wrap_i     (wrap),
      .sw_load_i  (cnt_load),
      .ack_i      (samp_ack_i),
      .irq_en_i   (ctrl_q.irq_en),
      .armed_o    (armed),
      .req_o      (samp_req_o),
      .ack_take_o (ack_take),
      .irq_o      (irq_o)
   );

endmodule

// File: rtl/evsamp_chk.sv
module evsamp_chk #(
   parameter int unsigned CNT_W = 48
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             wr_en_i,
   input logic [CNT_W-1:0] count_o,
   input logic             irq_o,
   input logic             samp_req_o,
   input logic             samp_ack_i,
   input logic [CNT_W-1:0] reload_q,
   input logic             cnt_en
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   p_irq_after_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (count_o == '0) && ($past(count_o) == '1));

   p_wrap_no_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> !$rose(samp_req_o));

   p_fire_at_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(samp_req_o) |-> (count_o == ONE));

   p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (samp_req_o && !samp_ack_i) |=> samp_req_o);

   p_ack_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (samp_req_o && samp_ack_i && !wr_en_i) |=>
         (!samp_req_o && count_o == $past(reload_q)));

   p_hold_disabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cnt_en && !wr_en_i && !(samp_req_o && samp_ack_i)) |=> $stable(count_o));

endmodule

bind evsamp_unit evsamp_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .wr_en_i    (wr_en_i),
   .count_o    (count_o),
   .irq_o      (irq_o),
   .samp_req_o (samp_req_o),
   .samp_ack_i (samp_ack_i),
   .reload_q   (reload_q),
   .cnt_en     (ctrl_q.cnt_en)
);

// File: tb/evsamp_unit_tb.sv
module evsamp_unit_tb_top;

   localparam int  W      = 6;
   localparam int  MOD    = 1 << W;
   localparam time PERIOD = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         evt = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] count;
   logic         irq;
   logic         req;
   logic         ack = 1'b0;

   int n_tot  = 0;
   int n_fail = 0;

   always #(PERIOD/2) clk = ~clk;

   evsamp_unit #(.CNT_W(W), .EVT_STAGES(0)) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .evt_i      (evt),
      .wr_en_i    (wr_en),
      .wr_sel_i   (wr_sel),
      .wr_data_i  (wr_data),
      .count_o    (count),
      .irq_o      (irq),
      .samp_req_o (req),
      .samp_ack_i (ack)
   );

   task automatic check(input string rq, input int act, input int exp);
      n_tot++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   // drive one cycle from a falling edge; outputs are read at the next falling edge
   task automatic cyc(input logic e, input logic a, input logic w,
                      input logic [1:0] s, input int d);
      evt = e; ack = a; wr_en = w; wr_sel = s; wr_data = W'(d);
      @(negedge clk);
      evt = 1'b0; ack = 1'b0; wr_en = 1'b0;
   endtask

   task automatic ev();                 cyc(1'b1, 1'b0, 1'b0, 2'd0, 0); endtask
   task automatic wr(input int s, input int d); cyc(1'b0, 1'b0, 1'b1, 2'(s), d); endtask
   task automatic ak();                 cyc(1'b0, 1'b1, 1'b0, 2'd0, 0); endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
   endtask

   initial begin
      #(PERIOD * 200000);
      n_tot++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 count", int'(count), 0);
      check("R11 irq", int'(irq), 0);
      check("R11 req", int'(req), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 disabled: events ignored
      repeat (3) ev();
      check("R1 disabled hold", int'(count), 0);

      // R10 encodings, R1 counting
      wr(2, 3);
      wr(0, 10);
      check("R10 count write", int'(count), 10);
      wr(3, 40);
      check("R10 sel3 ignored", int'(count), 10);
      repeat (5) ev();
      check("R1 count up", int'(count), 15);

      // R2 interrupt disabled, R3 arm, R4 fire
      wr(2, 1);
      wr(0, MOD - 1);
      ev();
      check("R2 no irq when off", int'(irq), 0);
      check("R3 no req on wrap", int'(req), 0);
      check("R1 wrap to zero", int'(count), 0);
      ev();
      check("R4 req after arm", int'(req), 1);
      check("R4 count one", int'(count), 1);
      ev();
      check("R5 req held", int'(req), 1);
      ak();
      check("R6 req dropped", int'(req), 0);
      check("R6 reload zero", int'(count), 0);

      // R5 stray ack
      wr(0, 20);
      ak();
      check("R5 stray ack count", int'(count), 20);
      check("R5 stray ack req", int'(req), 0);

      // R8 write clears arm; R2 irq pulse
      wr(2, 3);
      wr(0, MOD - 1);
      ev();
      check("R2 irq on wrap", int'(irq), 1);
      wr(0, 5);
      check("R2 irq one cycle", int'(irq), 0);
      ev();
      check("R8 no fire after write", int'(req), 0);
      check("R8 count", int'(count), 6);
      // R8 write beats event
      cyc(1'b1, 1'b0, 1'b1, 2'd0, 33);
      check("R8 write priority", int'(count), 33);

      // R6 reload beats coincident event
      wr(1, 50);
      wr(0, MOD - 1);
      ev();
      ev();
      check("R4 req", int'(req), 1);
      cyc(1'b1, 1'b1, 1'b0, 2'd0, 0);
      check("R6 reload priority", int'(count), 50);
      check("R6 req cleared", int'(req), 0);

      // R7 wrap during pending
      wr(1, MOD - 1);
      wr(0, MOD - 1);
      ev();
      ev();
      check("R7 req", int'(req), 1);
      repeat (MOD - 2) ev();
      check("R7 count advances", int'(count), MOD - 1);
      ev();
      check("R7 wrap while pending", int'(count), 0);
      check("R7 irq still", int'(irq), 1);
      ev();
      ak();
      check("R7 ack reload", int'(count), MOD - 1);
      ev();
      check("R7 no stale arm", int'(req), 0);
      ev();
      check("R7 fresh fire", int'(req), 1);
      ak();

      // R9 ratio sweep
      for (int n = 1; n <= 8; n++) begin
         wr(1, MOD - n);
         wr(0, MOD - n);
         for (int rep = 0; rep < 3; rep++) begin
            for (int i = 1; i <= n + 1; i++) begin
               ev();
               check("R9 request position", int'(req), (i == n + 1) ? 1 : 0);
               if (i == n) check("R3 wrap irq", int'(irq), 1);
            end
            ak();
            check("R9 reload value", int'(count), MOD - n);
         end
      end

      finish_run();
   end

endmodule